// File: doc/BRIEF.md
# Quire Register Binding Tracker

This block sits beside the floating-point issue stage and keeps track of which architectural floating-point registers currently stand for the contents of one of a small pool of wide exact accumulators (quires). Ordinary fused multiply-add code then accumulates exactly without being rewritten. A multiply-add claims a quire for its destination. When its addend register is already bound, it keeps accumulating into that quire, so a chain `rd = a*b + rd` builds a whole dot product in one quire. The bound value is rounded back into the register only when some instruction reads that register.

For each decoded instruction the block looks up rd, rs1, rs2 and rs3 in the binding table in the same cycle. It then does one of three things. It issues a conversion request, which stalls the instruction. It returns an allocation or ownership-transfer decision and accepts the instruction. Or it simply accepts the instruction. The table can be read and written one entry at a time through a control/status port, so that a context switch can save and restore it. The arithmetic and the rounding datapath live elsewhere.

Top module: `quire_bind_tracker`

## Requirements
- R1: After reset every quire is free: a status read of any entry returns valid bit 0.
- R2: Instruction class `ins_cls_i` is coded 0 = FP operation (reads rs1 and rs2, writes rd), 1 = fused multiply-add (reads rs1, rs2 and rs3, writes rd), 2 = FP load (writes rd), 3 = FP store (reads rs2 as data). When a read operand is bound, the block raises `cvt_valid_o` with that quire and register, holds `ins_ready_o` low, and frees the quire at the next clock edge.
- R3: At most one conversion is requested per cycle, rs1 before rs2. The instruction is accepted only in a cycle with no conversion pending, and a conversion never coincides with an allocation.
- R4: A multiply-add whose rs3 is bound, and whose rs1 and rs2 are not, is accepted in that cycle with `alloc_xfer_o`=1 and that same quire. The quire is then bound to rd.
- R5: A multiply-add whose rs3 is unbound is accepted with `alloc_xfer_o`=0 on the lowest-index quire that is free or is bound to rd. That quire is then bound to rd.
- R6: A multiply-add whose rs3 equals a bound rs1 or rs2 first converts that quire, and then takes a fresh allocation with no transfer.
- R7: When a fresh allocation finds every quire bound to other registers, the least recently bound quire is converted and freed first, with the instruction stalled one cycle, and is allocated in the next cycle. Both a fresh binding and a transfer count as binding.
- R8: An accepted FP operation or load whose rd is bound drops that binding without any conversion. So does a multiply-add that lands in a different quire.
- R9: A status read returns `{valid, register}` of the selected entry in the same cycle, with the valid bit at bit RW. A status write replaces the entry at the next edge, and in that cycle the block accepts no instruction and issues no request.
- R10: A chain of multiply-adds that share rd and rs3 uses a single quire, and the first conversion happens when a store reads that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Decoded FP instruction present |
| ins_cls_i | input | 2 | Instruction class (see R2) |
| rd_i | input | RW | Destination register |
| rs1_i | input | RW | First source register |
| rs2_i | input | RW | Second source register |
| rs3_i | input | RW | Addend register |
| ins_ready_o | output | 1 | Instruction accepted this cycle |
| cvt_valid_o | output | 1 | Round quire into register request |
| cvt_quire_o | output | QW | Quire to convert |
| cvt_reg_o | output | RW | Register receiving the conversion |
| alloc_valid_o | output | 1 | Multiply-add quire decision valid |
| alloc_xfer_o | output | 1 | 1 = accumulate into existing quire, 0 = fresh quire |
| alloc_quire_o | output | QW | Quire used by the multiply-add |
| csr_sel_i | input | QW | Table entry selected for status access |
| csr_we_i | input | 1 | Status write strobe |
| csr_wdata_i | input | RW+1 | Entry written: valid bit at RW, register below |
| csr_rdata_o | output | RW+1 | Entry read: valid bit at RW, register below |

## Verification
The bench goes after the cases where the lookups collide. One is a multiply-add whose addend is also rs1. A design that transferred ownership there would read an unconverted operand. Another is an operation with both sources bound, where issuing both conversions together or in the wrong order would lose one quire's value. A third is a full pool: a wrong victim would round away the accumulation that is still live. A load over a bound register must drop the binding silently, since a conversion there would write a stale value over the fresh data. Random streams over a handful of registers mix all of these cases against a reference table kept in the bench.

// File: rtl/qt_pkg.sv
package qt_pkg;
  typedef enum logic [1:0] {
    CLS_OP    = 2'd0,
    CLS_FMA   = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } ins_cls_e;
endpackage

// File: rtl/qt_match.sv
module qt_match #(
  parameter int NQ = 2,
  parameter int RW = 5
) (
  input  logic [NQ-1:0]         vld_i,
  input  logic [NQ-1:0][RW-1:0] reg_i,
  input  logic                  en_i,
  input  logic [RW-1:0]         key_i,
  output logic [NQ-1:0]         hit_o
);
  for (genvar g = 0; g < NQ; g++) begin : g_cmp
    assign hit_o[g] = en_i & vld_i[g] & (reg_i[g] == key_i);
  end
endmodule

// File: rtl/qt_penc.sv
module qt_penc #(
  parameter int N = 2,
  parameter int W = 1
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/qt_lru.sv
// Rank permutation: 0 = most recently bound, NQ-1 = oldest.
module qt_lru #(
  parameter int NQ = 2,
  parameter int QW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [QW-1:0] touch_q_i,
  output logic [QW-1:0] victim_o
);
  logic [NQ-1:0][QW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NQ; i++) age_q[i] <= QW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NQ; i++) begin
        if (QW'(i) == touch_q_i) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_q_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NQ; i++) begin
      if (age_q[i] == QW'(NQ - 1)) victim_o = QW'(i);
    end
  end
endmodule

// File: rtl/quire_bind_tracker.sv
module quire_bind_tracker
  import qt_pkg::*;
#(
  parameter int NQ = 2,
  parameter int RW = 5,
  parameter int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ins_valid_i,
  input  logic [1:0]    ins_cls_i,
  input  logic [RW-1:0] rd_i,
  input  logic [RW-1:0] rs1_i,
  input  logic [RW-1:0] rs2_i,
  input  logic [RW-1:0] rs3_i,
  output logic          ins_ready_o,
  output logic          cvt_valid_o,
  output logic [QW-1:0] cvt_quire_o,
  output logic [RW-1:0] cvt_reg_o,
  output logic          alloc_valid_o,
  output logic          alloc_xfer_o,
  output logic [QW-1:0] alloc_quire_o,
  input  logic [QW-1:0] csr_sel_i,
  input  logic          csr_we_i,
  input  logic [RW:0]   csr_wdata_i,
  output logic [RW:0]   csr_rdata_o
);
  ins_cls_e cls;
  assign cls = ins_cls_e'(ins_cls_i);

  logic [NQ-1:0]         vld_q, vld_nxt, clr;
  logic [NQ-1:0][RW-1:0] reg_q;

  logic use_rs1, use_rs2, use_rs3, use_rd;
  assign use_rs1 = ins_valid_i & ((cls == CLS_OP) | (cls == CLS_FMA));
  assign use_rs2 = ins_valid_i & (cls != CLS_LOAD);
  assign use_rs3 = ins_valid_i & (cls == CLS_FMA);
  assign use_rd  = ins_valid_i & (cls != CLS_STORE);

  logic [NQ-1:0] hit1, hit2, hit3, hitd, avail;
  qt_match #(.NQ(NQ), .RW(RW)) u_m1 (.vld_i(vld_q), .reg_i(reg_q), .en_i(use_rs1), .key_i(rs1_i), .hit_o(hit1));
  qt_match #(.NQ(NQ), .RW(RW)) u_m2 (.vld_i(vld_q), .reg_i(reg_q), .en_i(use_rs2), .key_i(rs2_i), .hit_o(hit2));
  qt_match #(.NQ(NQ), .RW(RW)) u_m3 (.vld_i(vld_q), .reg_i(reg_q), .en_i(use_rs3), .key_i(rs3_i), .hit_o(hit3));
  qt_match #(.NQ(NQ), .RW(RW)) u_md (.vld_i(vld_q), .reg_i(reg_q), .en_i(use_rd),  .key_i(rd_i),  .hit_o(hitd));

  // rd's own quire is reusable: its value dies with the write
  assign avail = ~vld_q | hitd;

  logic          any1, any2, any3, anyd, anyf;
  logic [QW-1:0] q1, q2, q3, qd, qf, victim;
  qt_penc #(.N(NQ), .W(QW)) u_p1 (.req_i(hit1),  .any_o(any1), .idx_o(q1));
  qt_penc #(.N(NQ), .W(QW)) u_p2 (.req_i(hit2),  .any_o(any2), .idx_o(q2));
  qt_penc #(.N(NQ), .W(QW)) u_p3 (.req_i(hit3),  .any_o(any3), .idx_o(q3));
  qt_penc #(.N(NQ), .W(QW)) u_pd (.req_i(hitd),  .any_o(anyd), .idx_o(qd));
  qt_penc #(.N(NQ), .W(QW)) u_pf (.req_i(avail), .any_o(anyf), .idx_o(qf));

  logic          bind_en;
  logic [QW-1:0] bind_q;

  qt_lru #(.NQ(NQ), .QW(QW)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(bind_en), .touch_q_i(bind_q), .victim_o(victim)
  );

  always_comb begin
    ins_ready_o   = 1'b0;
    cvt_valid_o   = 1'b0;
    cvt_quire_o   = '0;
    cvt_reg_o     = '0;
    alloc_valid_o = 1'b0;
    alloc_xfer_o  = 1'b0;
    alloc_quire_o = '0;
    clr           = '0;
    bind_en       = 1'b0;
    bind_q        = '0;
    if (csr_we_i) begin
      // status write owns the cycle
    end else if (any1) begin
      cvt_valid_o = 1'b1;
      cvt_quire_o = q1;
      cvt_reg_o   = rs1_i;
      clr[q1]     = 1'b1;
    end else if (any2) begin
      cvt_valid_o = 1'b1;
      cvt_quire_o = q2;
      cvt_reg_o   = rs2_i;
      clr[q2]     = 1'b1;
    end else if (use_rs3) begin
      if (any3) begin
        ins_ready_o   = 1'b1;
        alloc_valid_o = 1'b1;
        alloc_xfer_o  = 1'b1;
        alloc_quire_o = q3;
        bind_en       = 1'b1;
        bind_q        = q3;
        if (anyd && (qd != q3)) clr[qd] = 1'b1;
      end else if (anyf) begin
        ins_ready_o   = 1'b1;
        alloc_valid_o = 1'b1;
        alloc_quire_o = qf;
        bind_en       = 1'b1;
        bind_q        = qf;
        if (anyd) clr[qd] = 1'b1;
      end else begin
        cvt_valid_o = 1'b1;
        cvt_quire_o = victim;
        cvt_reg_o   = reg_q[victim];
        clr[victim] = 1'b1;
      end
    end else if (ins_valid_i) begin
      ins_ready_o = 1'b1;
      if (anyd) clr[qd] = 1'b1;
    end
  end

  always_comb begin
    vld_nxt = vld_q & ~clr;
    if (bind_en) vld_nxt[bind_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      reg_q <= '0;
    end else if (csr_we_i) begin
      vld_q[csr_sel_i] <= csr_wdata_i[RW];
      reg_q[csr_sel_i] <= csr_wdata_i[RW-1:0];
    end else begin
      vld_q <= vld_nxt;
      if (bind_en) reg_q[bind_q] <= rd_i;
    end
  end

  assign csr_rdata_o = {vld_q[csr_sel_i], reg_q[csr_sel_i]};
endmodule

// File: rtl/qt_checker.sv
module qt_checker #(
  parameter int NQ = 2,
  parameter int RW = 5,
  parameter int QW = 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ins_valid_i,
  input logic [1:0]            ins_cls_i,
  input logic [RW-1:0]         rd_i,
  input logic                  ins_ready_o,
  input logic                  cvt_valid_o,
  input logic [QW-1:0]         cvt_quire_o,
  input logic                  alloc_valid_o,
  input logic [QW-1:0]         alloc_quire_o,
  input logic                  csr_we_i,
  input logic [NQ-1:0]         vld_q,
  input logic [NQ-1:0][RW-1:0] reg_q
);
  AST_CVT_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cvt_valid_o |-> !ins_ready_o); // R2
  AST_CVT_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cvt_valid_o |=> !vld_q[$past(cvt_quire_o)]); // R2
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cvt_valid_o && alloc_valid_o)); // R3
  AST_FMA_DECIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_ready_o && ins_cls_i == 2'd1) |-> alloc_valid_o); // R5
  AST_ALLOC_BINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_o |=> (vld_q[$past(alloc_quire_o)] && reg_q[$past(alloc_quire_o)] == $past(rd_i))); // R4
  AST_CSR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i |-> (!ins_ready_o && !cvt_valid_o && !alloc_valid_o)); // R9
endmodule

bind quire_bind_tracker qt_checker #(.NQ(NQ), .RW(RW), .QW(QW)) u_chk (.*);

// File: tb/quire_bind_tracker_tb.sv
`timescale 1ns/1ps
module quire_bind_tracker_tb;
  localparam int NQ = 2;
  localparam int RW = 5;
  localparam int QW = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ins_valid = 1'b0, csr_we = 1'b0;
  logic [1:0] cls = '0;
  logic [RW-1:0] rd = '0, rs1 = '0, rs2 = '0, rs3 = '0;
  logic [QW-1:0] csr_sel = '0;
  logic [RW:0] csr_wdata = '0, csr_rdata;
  logic ready, cvt_v, alloc_v, xfer;
  logic [QW-1:0] cvt_q, alloc_q;
  logic [RW-1:0] cvt_r;

  always #4 clk = ~clk;

  quire_bind_tracker #(.NQ(NQ), .RW(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ins_valid_i(ins_valid), .ins_cls_i(cls),
    .rd_i(rd), .rs1_i(rs1), .rs2_i(rs2), .rs3_i(rs3),
    .ins_ready_o(ready), .cvt_valid_o(cvt_v), .cvt_quire_o(cvt_q), .cvt_reg_o(cvt_r),
    .alloc_valid_o(alloc_v), .alloc_xfer_o(xfer), .alloc_quire_o(alloc_q),
    .csr_sel_i(csr_sel), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference table
  bit mv[NQ], nv[NQ];
  int mr[NQ], nr[NQ], ma[NQ], na[NQ];
  bit e_rdy, e_cvt, e_alloc, e_xfer;
  int e_cq, e_cr, e_aq;

  function automatic int find(int r);
    for (int q = 0; q < NQ; q++) if (mv[q] && mr[q] == r) return q;
    return -1;
  endfunction

  function automatic void touch(int q);
    for (int p = 0; p < NQ; p++) if (p != q && ma[p] < ma[q]) na[p] = ma[p] + 1;
    na[q] = 0;
  endfunction

  function automatic void model(int c, int d, int s1, int s2, int s3);
    int q1, q2, q3, qd, qf;
    e_rdy = 0; e_cvt = 0; e_alloc = 0; e_xfer = 0; e_cq = 0; e_cr = 0; e_aq = 0;
    for (int q = 0; q < NQ; q++) begin nv[q] = mv[q]; nr[q] = mr[q]; na[q] = ma[q]; end
    q1 = (c == 0 || c == 1) ? find(s1) : -1;
    q2 = (c != 2) ? find(s2) : -1;
    qd = (c != 3) ? find(d) : -1;
    if (q1 >= 0) begin e_cvt = 1; e_cq = q1; e_cr = s1; nv[q1] = 0; end
    else if (q2 >= 0) begin e_cvt = 1; e_cq = q2; e_cr = s2; nv[q2] = 0; end
    else if (c == 1) begin
      q3 = find(s3);
      if (q3 >= 0) begin
        e_rdy = 1; e_alloc = 1; e_xfer = 1; e_aq = q3;
        if (qd >= 0 && qd != q3) nv[qd] = 0;
        nv[q3] = 1; nr[q3] = d; touch(q3);
      end else begin
        qf = -1;
        for (int q = NQ - 1; q >= 0; q--) if (!mv[q] || q == qd) qf = q;
        if (qf >= 0) begin
          e_rdy = 1; e_alloc = 1; e_aq = qf;
          if (qd >= 0) nv[qd] = 0;
          nv[qf] = 1; nr[qf] = d; touch(qf);
        end else begin
          for (int q = 0; q < NQ; q++) if (ma[q] == NQ - 1) e_cq = q;
          e_cvt = 1; e_cr = mr[e_cq]; nv[e_cq] = 0;
        end
      end
    end else begin
      e_rdy = 1;
      if (qd >= 0) nv[qd] = 0;
    end
  endfunction

  task automatic check_outs(string tag);
    bit ok;
    ok = (ready == e_rdy) && (cvt_v == e_cvt) && (alloc_v == e_alloc);
    if (e_cvt) ok = ok && (int'(cvt_q) == e_cq) && (int'(cvt_r) == e_cr);
    if (e_alloc) ok = ok && (int'(alloc_q) == e_aq) && (xfer == e_xfer);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got rdy=%0d cvt=%0d q%0d r%0d alloc=%0d q%0d x%0d exp rdy=%0d cvt=%0d q%0d r%0d alloc=%0d q%0d x%0d",
               tag, ready, cvt_v, cvt_q, cvt_r, alloc_v, alloc_q, xfer,
               e_rdy, e_cvt, e_cq, e_cr, e_alloc, e_aq, e_xfer);
    end
  endtask

  task automatic issue(int c, int d, int s1, int s2, int s3, string tag);
    bit done = 0;
    for (int g = 0; g < 6 && !done; g++) begin
      @(negedge clk);
      ins_valid = 1; cls = 2'(c); rd = RW'(d); rs1 = RW'(s1); rs2 = RW'(s2); rs3 = RW'(s3);
      #1;
      model(c, d, s1, s2, s3);
      check_outs(tag);
      @(posedge clk);
      for (int q = 0; q < NQ; q++) begin mv[q] = nv[q]; mr[q] = nr[q]; ma[q] = na[q]; end
      done = e_rdy;
    end
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic csr_check(int sel, int v, int r, string tag);
    @(negedge clk);
    csr_sel = QW'(sel);
    #1;
    n_chk++;
    if (csr_rdata != {1'(v), RW'(r)}) begin
      n_fail++;
      $display("FAIL %s: entry %0d got %0h exp %0h", tag, sel, csr_rdata, {1'(v), RW'(r)});
    end
  endtask

  task automatic csr_write(int sel, int v, int r);
    @(negedge clk);
    csr_we = 1; csr_sel = QW'(sel); csr_wdata = {1'(v), RW'(r)};
    ins_valid = 1; cls = 2'd1; rd = 5'd30; rs1 = 5'd29; rs2 = 5'd28; rs3 = 5'd27;
    #1;
    n_chk++;
    if (ready || cvt_v || alloc_v) begin
      n_fail++;
      $display("FAIL R9: during write got rdy=%0d cvt=%0d alloc=%0d exp 0 0 0", ready, cvt_v, alloc_v);
    end
    @(posedge clk);
    mv[sel] = 1'(v); mr[sel] = r;
    @(negedge clk);
    csr_we = 0; ins_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got hang exp completion");
    if (!finished) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int q = 0; q < NQ; q++) begin mv[q] = 0; mr[q] = 0; ma[q] = q; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    csr_check(0, 0, 0, "R1");
    csr_check(1, 0, 0, "R1");
    // dot product chain
    issue(2, 7, 0, 0, 0, "R8 load");
    issue(1, 7, 1, 2, 7, "R5 fresh");
    issue(1, 7, 3, 4, 7, "R4 xfer");
    issue(1, 7, 5, 6, 7, "R10 chain");
    csr_check(0, 1, 7, "R10");
    issue(3, 0, 0, 7, 0, "R10 store");
    csr_check(0, 0, 7, "R2");
    // full pool eviction
    issue(1, 3, 1, 2, 9, "R5");
    issue(1, 4, 1, 2, 10, "R5");
    issue(1, 5, 1, 2, 11, "R7 evict");
    // addend also rs1
    issue(1, 5, 5, 1, 5, "R6");
    // two bound sources
    issue(1, 8, 1, 2, 13, "R5");
    issue(0, 6, 5, 8, 0, "R3 order");
    // silent drop
    issue(1, 12, 1, 2, 20, "R5");
    issue(2, 12, 0, 0, 0, "R8 drop");
    csr_check(0, 0, 12, "R8");
    csr_write(1, 1, 15);
    csr_check(1, 1, 15, "R9");
    issue(3, 0, 0, 15, 0, "R9 restore");
    // random mix
    for (int i = 0; i < 400; i++) begin
      issue(int'($urandom_range(0, 3)), int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
            int'($urandom_range(0, 5)), int'($urandom_range(0, 5)), "R2 R3 R4 R5 R6 R7 R8 random");
    end
    for (int q = 0; q < NQ; q++) csr_check(q, mv[q], mr[q], "R9 final");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule